// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures the period of one of three slow clocks against a fast reference clock. It counts how many reference cycles pass during a programmed number of slow-clock periods. Software then turns that count into a period or a frequency. All logic runs on the reference clock. Each slow clock enters through its own two-flop synchronizer, and a rising edge of the synchronized signal marks one slow period.

Software programs the block through a single configuration write strobe. One write loads all of the fields together: source select, window length in slow periods, the one-off start bit, the cycling-enable bit and the timeout threshold.

There are two ways to run a measurement:
- **One-off mode** starts on a 0-to-1 transition of the start bit while cycling is disabled. When the window ends, `cal_ready` is set and the result is held.
- **Cycling mode** is enabled out of reset. It measures windows back to back and sets `cal_cyc_valid` each time a new result is stored.

A timeout threshold bounds every window. If a window runs too long, `cal_timeout` is set and the engine returns to idle, ready for a clean new run. Writing a small threshold (for example 1) is also how software cuts a long cycling window short.

The engine has three states:
- **IDLE** goes to **ALIGN** on *cycle-start* (cycling enabled, window length non-zero, no timeout pending) or on *one-off-start* (cycling disabled, rising edge of the start bit, window length non-zero).
- **ALIGN** waits for the first slow edge and goes to **COUNT** on *align-edge*. It returns to IDLE on *timeout* or on *abort* (cycling cleared during a cycling run).
- **COUNT** counts reference cycles. On *window-end* it goes back to COUNT if cycling is still enabled, and otherwise to IDLE. On *timeout* or *abort* it goes to IDLE.

Top module: `slow_clk_cal`

## Requirements
- R1: Out of reset the select field is 0, the window length is RST_MAX (1), cycling is enabled, the threshold is RST_THR (255), and `cal_value`, `cal_ready`, `cal_cyc_valid` and `cal_timeout` are all 0. The block therefore starts measuring source 0 by itself.
- R2: In one-off mode the stored result is N×P, where N is the window length and P is the selected source's period in reference cycles. The window runs from one synchronized rising edge to the N-th rising edge after it. At window end `cal_ready` rises and `cal_value` holds the result until the next completion.
- R3: A one-off run starts only on a 0-to-1 transition of the start field. Writing the start field as 1 again when it is already 1 starts nothing.
- R4: In cycling mode windows follow one another with no gap. Each window stores N×P and sets `cal_cyc_valid`. `cal_ready` is never set by a cycling window.
- R5: A window length of 0 starts no measurement, in either mode.
- R6: Every window, including its alignment phase, is bounded by threshold×2^TMO_SHIFT reference cycles (4096 per threshold unit by default). When the bound is reached, `cal_timeout` is set, the engine returns to IDLE and `cal_ready` is not set. A later run then measures correctly. Cycling does not restart while `cal_timeout` is pending.
- R7: Writing a threshold of 1 during a long cycling window forces a timeout within 4096 reference cycles.
- R8: Any configuration write clears `cal_ready`, `cal_cyc_valid` and `cal_timeout` in the next cycle. The start of a new run also clears them.
- R9: The result is CNT_W bits wide and saturates at all ones instead of wrapping.
- R10: `cal_ready` and `cal_timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | NSRC (3) | Slow clocks to measure; any phase relative to clk_ref |
| cfg_we | input | 1 | Configuration write strobe; loads all cfg_* fields |
| cfg_sel | input | SEL_W (2) | Source select; values of NSRC or above select no source |
| cfg_max | input | MAX_W (16) | Window length in slow periods |
| cfg_oneoff | input | 1 | One-off start bit; a 0-to-1 transition starts a run |
| cfg_cycle | input | 1 | Cycling-mode enable |
| cfg_thr | input | THR_W (8) | Timeout threshold, in units of 2^TMO_SHIFT reference cycles |
| cal_value | output | CNT_W (32) | Last measured reference-cycle count, saturating |
| cal_ready | output | 1 | One-off result ready |
| cal_cyc_valid | output | 1 | A cycling window result has been stored |
| cal_timeout | output | 1 | The last window exceeded the threshold |

## Verification
The assertions assume software follows the programming rules:
- select and window length are never changed while a window runs, except when cycling is cleared or a timeout is forced;
- each write is a single-cycle `cfg_we` pulse.

The stimulus keeps to these rules. Every one-off run is preceded by a write that disables cycling and leaves the start bit low, followed by a write that raises it. Each slow clock is produced at a fixed period that is a whole number of reference cycles, so the expected result N×P is exact. The timeout cases use the unconnected select code 3, or a threshold rewrite made while cycling is enabled.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_COUNT = 2'd2
    } cal_state_e;
endpackage

// File: rtl/cal_edge_sync.sv
module cal_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] && !last_q;
endmodule

// File: rtl/cal_tmo_timer.sv
module cal_tmo_timer #(
    parameter int THR_W = 8,
    parameter int SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [THR_W-1:0] thr,
    output logic             expired
);
    localparam int TW = THR_W + SHIFT + 1;

    logic [TW-1:0] tcnt_q;
    logic [TW-1:0] limit;

    assign limit = TW'(thr) << SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
        end else if (clear) begin
            tcnt_q <= '0;
        end else if (run && (tcnt_q != {TW{1'b1}})) begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    assign expired = run && (tcnt_q >= limit);
endmodule

// File: rtl/slow_clk_cal.sv
module slow_clk_cal #(
    parameter int NSRC      = 3,
    parameter int SEL_W     = 2,
    parameter int MAX_W     = 16,
    parameter int CNT_W     = 32,
    parameter int THR_W     = 8,
    parameter int TMO_SHIFT = 12,
    parameter int SYNC_LEN  = 2,
    parameter int RST_MAX   = 1,
    parameter int RST_THR   = 255
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  slow_clk,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [MAX_W-1:0] cfg_max,
    input  logic             cfg_oneoff,
    input  logic             cfg_cycle,
    input  logic [THR_W-1:0] cfg_thr,
    output logic [CNT_W-1:0] cal_value,
    output logic             cal_ready,
    output logic             cal_cyc_valid,
    output logic             cal_timeout
);
    import cal_pkg::*;

    localparam logic [MAX_W-1:0] MAX_RST = MAX_W'(RST_MAX);
    localparam logic [THR_W-1:0] THR_RST = THR_W'(RST_THR);

    // configuration fields
    logic [SEL_W-1:0] sel_q;
    logic [MAX_W-1:0] max_q;
    logic             oneoff_q, oneoff_prev_q, cyc_q;
    logic [THR_W-1:0] thr_q;

    // engine state
    cal_state_e       st_q, st_d;
    logic             mode_cyc_q;
    logic [CNT_W-1:0] ref_cnt_q;
    logic [MAX_W-1:0] edge_cnt_q;

    logic [NSRC-1:0]  rise_v;
    logic             sel_edge;
    logic             start_cyc, start_one, run_start;
    logic             win_end, tmo_exp, tmo_hit, abort, busy;
    logic [CNT_W-1:0] result;

    for (genvar i = 0; i < NSRC; i++) begin : g_sync
        cal_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
            .clk      (clk_ref),
            .rst_n    (rst_n),
            .async_in (slow_clk[i]),
            .rise     (rise_v[i])
        );
    end

    always_comb begin
        sel_edge = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel_q == SEL_W'(i)) sel_edge = rise_v[i];
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign start_cyc = cyc_q && (max_q != '0) && !cal_timeout;
    assign start_one = !cyc_q && oneoff_q && !oneoff_prev_q && (max_q != '0);
    assign run_start = (st_q == ST_IDLE) && (start_cyc || start_one);
    assign abort     = mode_cyc_q && !cyc_q;
    assign win_end   = (st_q == ST_COUNT) && sel_edge &&
                       (({1'b0, edge_cnt_q} + 1'b1) >= {1'b0, max_q});
    assign tmo_hit   = busy && tmo_exp && !win_end;
    assign result    = (ref_cnt_q == {CNT_W{1'b1}}) ? ref_cnt_q : ref_cnt_q + 1'b1;

    cal_tmo_timer #(.THR_W(THR_W), .SHIFT(TMO_SHIFT)) u_tmo (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .clear   (!busy || win_end),
        .run     (busy),
        .thr     (thr_q),
        .expired (tmo_exp)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_cyc || start_one) st_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (tmo_hit || abort)  st_d = ST_IDLE;
                else if (sel_edge)     st_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (win_end)              st_d = (mode_cyc_q && cyc_q) ? ST_COUNT : ST_IDLE;
                else if (tmo_hit || abort) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // configuration, counters and outputs
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            sel_q         <= '0;
            max_q         <= MAX_RST;
            oneoff_q      <= 1'b0;
            oneoff_prev_q <= 1'b0;
            cyc_q         <= 1'b1;
            thr_q         <= THR_RST;
            mode_cyc_q    <= 1'b0;
            ref_cnt_q     <= '0;
            edge_cnt_q    <= '0;
            cal_value     <= '0;
            cal_ready     <= 1'b0;
            cal_cyc_valid <= 1'b0;
            cal_timeout   <= 1'b0;
        end else begin
            oneoff_prev_q <= oneoff_q;
            if (cfg_we) begin
                sel_q    <= cfg_sel;
                max_q    <= cfg_max;
                oneoff_q <= cfg_oneoff;
                cyc_q    <= cfg_cycle;
                thr_q    <= cfg_thr;
            end
            if (run_start) mode_cyc_q <= start_cyc;

            if (((st_q == ST_ALIGN) && sel_edge) || win_end) begin
                ref_cnt_q  <= '0;
                edge_cnt_q <= '0;
            end else if (st_q == ST_COUNT) begin
                if (ref_cnt_q != {CNT_W{1'b1}}) ref_cnt_q <= ref_cnt_q + 1'b1;
                if (sel_edge) edge_cnt_q <= edge_cnt_q + 1'b1;
            end

            if (win_end) cal_value <= result;

            if (cfg_we) begin
                cal_ready     <= 1'b0;
                cal_cyc_valid <= 1'b0;
                cal_timeout   <= 1'b0;
            end else begin
                if (run_start) begin
                    cal_ready     <= 1'b0;
                    cal_cyc_valid <= 1'b0;
                    cal_timeout   <= 1'b0;
                end
                if (win_end) begin
                    if (mode_cyc_q) cal_cyc_valid <= 1'b1;
                    else            cal_ready     <= 1'b1;
                end
                if (tmo_hit) cal_timeout <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/slow_clk_cal_chk.sv
module slow_clk_cal_chk #(
    parameter int MAX_W = 16,
    parameter int CNT_W = 32
) (
    input logic                clk_ref,
    input logic                rst_n,
    input logic                cfg_we,
    input cal_pkg::cal_state_e st_q,
    input logic [MAX_W-1:0]    max_q,
    input logic                mode_cyc_q,
    input logic [CNT_W-1:0]    cal_value,
    input logic                cal_ready,
    input logic                cal_cyc_valid,
    input logic                cal_timeout
);
    import cal_pkg::*;

    // R10: one-off completion and timeout exclude each other
    a_r10_ready_vs_timeout: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(cal_ready && cal_timeout));

    // R2: result is held while ready stays up
    a_r2_value_held: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cal_ready && $past(cal_ready)) |-> $stable(cal_value));

    // R4: only one-off windows raise ready
    a_r4_ready_only_oneoff: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(cal_ready) |-> !$past(mode_cyc_q));

    // R5: zero window length leaves the engine idle
    a_r5_zero_max_idle: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st_q == ST_IDLE && max_q == '0 && !cfg_we) |=> (st_q == ST_IDLE));

    // R6: a timeout leaves the engine idle
    a_r6_timeout_idle: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(cal_timeout) |-> (st_q == ST_IDLE));

    // R8: a configuration write clears all flags
    a_r8_write_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cfg_we |=> (!cal_ready && !cal_cyc_valid && !cal_timeout));
endmodule

bind slow_clk_cal slow_clk_cal_chk #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_chk (
    .clk_ref       (clk_ref),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .st_q          (st_q),
    .max_q         (max_q),
    .mode_cyc_q    (mode_cyc_q),
    .cal_value     (cal_value),
    .cal_ready     (cal_ready),
    .cal_cyc_valid (cal_cyc_valid),
    .cal_timeout   (cal_timeout)
);

// File: tb/slow_clk_cal_tb.sv
module slow_clk_cal_tb;
    logic        clk_ref = 1'b0;
    logic        rst_n   = 1'b0;
    logic [2:0]  slow_clk = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_max = '0;
    logic        cfg_oneoff = 1'b0;
    logic        cfg_cycle = 1'b0;
    logic [7:0]  cfg_thr = '0;
    logic [31:0] cal_value;
    logic        cal_ready, cal_cyc_valid, cal_timeout;
    logic [7:0]  sat_value;
    logic        sat_ready, sat_valid, sat_tmo;

    int n_pass = 0;
    int n_total = 0;

    always #10 clk_ref = ~clk_ref;   // 50 MHz

    // slow sources: periods 20, 34, 50 reference cycles
    int half_c [3] = '{10, 17, 25};
    int sc [3] = '{0, 0, 0};
    always @(negedge clk_ref) begin
        for (int k = 0; k < 3; k++) begin
            if (sc[k] == half_c[k] - 1) begin
                sc[k] <= 0;
                slow_clk[k] <= ~slow_clk[k];
            end else begin
                sc[k] <= sc[k] + 1;
            end
        end
    end

    slow_clk_cal u_dut (
        .clk_ref(clk_ref), .rst_n(rst_n), .slow_clk(slow_clk),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_max(cfg_max),
        .cfg_oneoff(cfg_oneoff), .cfg_cycle(cfg_cycle), .cfg_thr(cfg_thr),
        .cal_value(cal_value), .cal_ready(cal_ready),
        .cal_cyc_valid(cal_cyc_valid), .cal_timeout(cal_timeout)
    );

    slow_clk_cal #(.CNT_W(8)) u_sat (
        .clk_ref(clk_ref), .rst_n(rst_n), .slow_clk(slow_clk),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_max(cfg_max),
        .cfg_oneoff(cfg_oneoff), .cfg_cycle(cfg_cycle), .cfg_thr(cfg_thr),
        .cal_value(sat_value), .cal_ready(sat_ready),
        .cal_cyc_valid(sat_valid), .cal_timeout(sat_tmo)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] max;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{sel: 2'd0, max: 16'd4, exp: 32'd80},
        '{sel: 2'd1, max: 16'd3, exp: 32'd102},
        '{sel: 2'd2, max: 16'd2, exp: 32'd100},
        '{sel: 2'd1, max: 16'd1, exp: 32'd34},
        '{sel: 2'd0, max: 16'd7, exp: 32'd140}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [15:0] m, input logic one,
                             input logic cyc, input logic [7:0] t);
        @(negedge clk_ref);
        cfg_we = 1'b1; cfg_sel = s; cfg_max = m; cfg_oneoff = one; cfg_cycle = cyc; cfg_thr = t;
        @(negedge clk_ref);
        cfg_we = 1'b0;
    endtask

    // which: 0 ready, 1 cycling valid, 2 timeout
    task automatic wait_flag(input int which, input int lim, output int n);
        logic f;
        n = 0;
        while (n < lim) begin
            f = (which == 0) ? cal_ready : (which == 1) ? cal_cyc_valid : cal_timeout;
            if (f) break;
            @(negedge clk_ref);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk_ref);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        repeat (5) @(negedge clk_ref);
        rst_n = 1'b1;
        @(negedge clk_ref);
        // R1: reset state
        chk(cal_value == 0 && !cal_ready && !cal_cyc_valid && !cal_timeout, "R1 reset flags", cal_value, 0);
        wait_flag(1, 500, n);
        chk(cal_cyc_valid, "R1 default cycling valid", cal_cyc_valid, 1);
        chk(cal_value == 20, "R1 default src0 window", cal_value, 20);

        // R2: table of one-off measurements
        for (int i = 0; i < 5; i++) begin
            cfg_write(VEC[i].sel, VEC[i].max, 1'b0, 1'b0, 8'd255);
            cfg_write(VEC[i].sel, VEC[i].max, 1'b1, 1'b0, 8'd255);
            wait_flag(0, 2000, n);
            chk(cal_ready, "R2 ready", cal_ready, 1);
            chk(cal_value == VEC[i].exp, "R2 value", cal_value, VEC[i].exp);
        end
        repeat (100) @(negedge clk_ref);
        chk(cal_ready && cal_value == 140, "R2 value held", cal_value, 140);

        // R8 and R3: rewrite start bit high without a transition
        cfg_write(2'd0, 16'd7, 1'b1, 1'b0, 8'd255);
        chk(!cal_ready, "R8 write clears ready", cal_ready, 0);
        repeat (400) @(negedge clk_ref);
        chk(!cal_ready, "R3 no restart on level", cal_ready, 0);

        // R9: saturation on the 8-bit instance, 8 x 50 = 400
        cfg_write(2'd2, 16'd8, 1'b0, 1'b0, 8'd255);
        cfg_write(2'd2, 16'd8, 1'b1, 1'b0, 8'd255);
        wait_flag(0, 2000, n);
        chk(cal_value == 400, "R2 long window", cal_value, 400);
        chk(sat_ready && sat_value == 8'hFF, "R9 saturate", sat_value, 255);

        // R4: cycling windows back to back
        cfg_write(2'd2, 16'd3, 1'b0, 1'b1, 8'd255);
        wait_flag(1, 2000, n);
        chk(cal_cyc_valid && cal_value == 150, "R4 first window", cal_value, 150);
        cfg_write(2'd2, 16'd3, 1'b0, 1'b1, 8'd255);
        chk(!cal_cyc_valid, "R8 write clears valid", cal_cyc_valid, 0);
        wait_flag(1, 200, n);
        chk(cal_cyc_valid && cal_value == 150, "R4 next window", cal_value, 150);
        chk(!cal_ready, "R4 no ready in cycling", cal_ready, 0);

        // R5: zero window length in both modes
        cfg_write(2'd0, 16'd0, 1'b0, 1'b0, 8'd255);
        cfg_write(2'd0, 16'd0, 1'b1, 1'b0, 8'd255);
        repeat (300) @(negedge clk_ref);
        chk(!cal_ready && !cal_timeout, "R5 one-off zero max", cal_ready, 0);
        cfg_write(2'd0, 16'd0, 1'b0, 1'b1, 8'd255);
        repeat (300) @(negedge clk_ref);
        chk(!cal_cyc_valid, "R5 cycling zero max", cal_cyc_valid, 0);

        // R6: timeout with no source selected, threshold 1
        cfg_write(2'd3, 16'd2, 1'b0, 1'b0, 8'd1);
        cfg_write(2'd3, 16'd2, 1'b1, 1'b0, 8'd1);
        wait_flag(2, 6000, n);
        chk(cal_timeout, "R6 timeout set", cal_timeout, 1);
        chk(n >= 4090 && n <= 4110, "R6 timeout latency", n, 4098);
        chk(!cal_ready, "R6 no ready on timeout", cal_ready, 0);
        cfg_write(2'd1, 16'd3, 1'b0, 1'b0, 8'd255);
        cfg_write(2'd1, 16'd3, 1'b1, 1'b0, 8'd255);
        wait_flag(0, 2000, n);
        chk(cal_ready && cal_value == 102 && !cal_timeout, "R6 recovery", cal_value, 102);

        // R7: cut a long cycling window short
        cfg_write(2'd2, 16'd1000, 1'b0, 1'b1, 8'd255);
        repeat (500) @(negedge clk_ref);
        cfg_write(2'd2, 16'd1000, 1'b0, 1'b1, 8'd1);
        wait_flag(2, 4200, n);
        chk(cal_timeout, "R7 forced timeout", cal_timeout, 1);
        chk(!cal_cyc_valid && !cal_ready, "R7 no result", cal_cyc_valid, 0);
        chk(!(cal_ready && cal_timeout), "R10 exclusive", cal_ready, 0);
        repeat (300) @(negedge clk_ref);
        chk(cal_timeout && !cal_cyc_valid, "R6 no cycling restart", cal_cyc_valid, 0);

        finish_run();
    end
endmodule